// File: doc/BRIEF.md
# Interrupt Flag Register with Level-Derived Sources

This block holds the 32-bit interrupt flag word for one processor. Single-cycle event pulses from timers, display, DMA, keypad, card, lid, serial, SPI and wireless sources are captured in sticky flag bits. Software clears a captured flag by writing a one to it. Three positions in the word are not stored at all. They are recomputed every cycle from FIFO status. Two of them come from the inter-processor message FIFO: its transmit side is empty, or its receive side holds data. The third comes from the fill level of the geometry command FIFO, compared against a threshold chosen by a two-bit mode.

A simple register bus reaches the flag word and a companion 32-bit enable word. Byte, halfword and word accesses are supported, and each access touches only its own byte lanes. Reads are combinational. A single interrupt request output is asserted when any flag that is also enabled is set and the master enable input is high.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every stored flag reads 0. A one-cycle pulse on `evt_pulse[i]` for a stored position i makes flag i read 1 from the next clock edge onward. The stored positions are bits 0-13, 16, 19, 20, 22, 23 and 24.
- R2: A write with data bit i = 1 in an accessed lane clears stored flag i at the clock edge. Data bit i = 0 leaves flag i unchanged.
- R3: When a clearing write and an event pulse hit the same stored flag in the same cycle, the flag stays set.
- R4: `bus_size` uses 0 = byte, 1 = halfword, 2 = word and 3 = invalid. Bytes are allowed at offsets 0-3 (`bus_addr[1:0]`), halfwords at offsets 0 and 2, and words at offset 0. Data sits in its natural lane, so lane k is bits 8k+7..8k. A write changes only the accessed lanes. A read returns the accessed lanes and zero in every other lane. A misaligned or invalid access writes nothing and reads 0.
- R5: Bits 14, 15 and 25-31 always read 0. Event pulses and writes on these bits have no effect.
- R6: Bit 17 reads 1 exactly when `ipc_fifo_en`, `ipc_send_irq_en` and `ipc_send_empty` are all 1. Bit 18 reads 1 exactly when `ipc_fifo_en` and `ipc_recv_irq_en` are 1 and `ipc_recv_empty` is 0.
- R7: Bit 21 depends on `gx_irq_mode`. In mode 1 it is 1 when `gx_fill` <= 127. In mode 2 it is 1 when `gx_fill` == 0. In modes 0 and 3 it is never 1.
- R8: Bits 17, 18 and 21 follow their inputs combinationally in the same cycle, and a write cannot clear them.
- R9: `bus_addr[2]` = 1 selects the enable word. It resets to 0 and obeys the lane rules of R4 for plain (non-clearing) writes and reads. `bus_addr[2]` = 0 selects the flag word.
- R10: `irq_out` = `master_en` AND (OR over all bits of flag word AND enable word). It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_addr | input | 3 | Bit 2 selects the enable word; bits 1:0 are the byte offset |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Read data, accessed lanes only |
| evt_pulse | input | 32 | Event pulses, one per flag position |
| ipc_fifo_en | input | 1 | Inter-processor FIFO enable |
| ipc_send_irq_en | input | 1 | Transmit-empty interrupt enable |
| ipc_send_empty | input | 1 | Transmit side of the inter-processor FIFO is empty |
| ipc_recv_irq_en | input | 1 | Receive-not-empty interrupt enable |
| ipc_recv_empty | input | 1 | Receive side of the inter-processor FIFO is empty |
| gx_irq_mode | input | 2 | Geometry FIFO condition select |
| gx_fill | input | 9 | Geometry FIFO entry count |
| master_en | input | 1 | Master interrupt enable |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions check the per-cycle laws on every cycle. A pulse sets its flag at the next edge, and an event wins over a clear. A clear without an event empties the flag. A flag holds when nothing touches it. Unassigned bits stay 0, the FIFO-derived bits are gated, and the request is gated by the master enable and by the mask. Only the bench scenarios can show that the lane decoding picks the correct bits for each offset and size, that misaligned accesses are fully inert, that the threshold sits at exactly 127 versus 128, and that the enable word reads back as written.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned LANES    = WORD_W / LANE_W;
  localparam int unsigned OFF_W    = $clog2(LANES);
  localparam int unsigned ADDR_W   = OFF_W + 1;

  // positions that exist in the flag word
  localparam logic [WORD_W-1:0] ASSIGNED_MASK = 32'h01FF_3FFF;

  localparam int unsigned POS_TX_EMPTY  = 17;
  localparam int unsigned POS_RX_AVAIL  = 18;
  localparam int unsigned POS_GX_THRESH = 21;

  localparam logic [WORD_W-1:0] LEVEL_MASK =
    (WORD_W'(1) << POS_TX_EMPTY) | (WORD_W'(1) << POS_RX_AVAIL) |
    (WORD_W'(1) << POS_GX_THRESH);

  localparam logic [WORD_W-1:0] STORED_MASK = ASSIGNED_MASK & ~LEVEL_MASK;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    GXM_NEVER = 2'd0,
    GXM_BELOW = 2'd1,
    GXM_EMPTY = 2'd2,
    GXM_RSVD  = 2'd3
  } gx_mode_e;

  // lanes touched by an access; misaligned or invalid gives none
  function automatic logic [LANES-1:0] lanes_for(logic [OFF_W-1:0] off, acc_size_e sz);
    logic [LANES-1:0] r;
    r = '0;
    case (sz)
      SZ_BYTE: r = LANES'(1) << off;
      SZ_HALF: r = off[0] ? '0 : (LANES'(3) << off);
      SZ_WORD: r = (off == '0) ? '1 : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

  // geometry FIFO threshold condition
  function automatic logic gx_hit(gx_mode_e m, int unsigned fill, int unsigned thresh);
    case (m)
      GXM_BELOW: return fill <= thresh;
      GXM_EMPTY: return fill == 0;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irqf_lane_decode.sv
module irqf_lane_decode
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] acc_bits,
  output logic [WORD_W-1:0] wr_flag_bits,
  output logic [WORD_W-1:0] wr_en_bits,
  output logic              sel_en
);
  logic [LANES-1:0] lanes;
  logic             misaligned;

  assign lanes  = lanes_for(addr[OFF_W-1:0], acc_size_e'(size));
  assign sel_en = addr[ADDR_W-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc_bits[g*LANE_W +: LANE_W] = {LANE_W{lanes[g]}};
  end

  assign wr_flag_bits = (wr && !sel_en) ? acc_bits : '0;
  assign wr_en_bits   = (wr &&  sel_en) ? acc_bits : '0;

  assign misaligned = (acc_size_e'(size) == SZ_BAD) ||
                      (acc_size_e'(size) == SZ_HALF && addr[0]) ||
                      (acc_size_e'(size) == SZ_WORD && addr[OFF_W-1:0] != '0);

  // R4: misaligned or invalid access reaches no lane
  a_r4_misaligned_inert: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (acc_bits == '0));

  // R4: a byte access touches exactly one lane
  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size_e'(size) == SZ_BYTE) |-> ($countones(acc_bits) == LANE_W));
endmodule

// File: rtl/irqf_level_gen.sv
module irqf_level_gen
  import irqf_pkg::*;
#(
  parameter int unsigned GX_CNT_W  = 9,
  parameter int unsigned GX_THRESH = 127
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ipc_fifo_en,
  input  logic                ipc_send_irq_en,
  input  logic                ipc_send_empty,
  input  logic                ipc_recv_irq_en,
  input  logic                ipc_recv_empty,
  input  logic [1:0]          gx_irq_mode,
  input  logic [GX_CNT_W-1:0] gx_fill,
  output logic [WORD_W-1:0]   level_bits
);
  logic tx_hit;
  logic rx_hit;
  logic gx_bit;

  assign tx_hit = ipc_fifo_en && ipc_send_irq_en && ipc_send_empty;
  assign rx_hit = ipc_fifo_en && ipc_recv_irq_en && !ipc_recv_empty;
  assign gx_bit = gx_hit(gx_mode_e'(gx_irq_mode), 32'(gx_fill), GX_THRESH);

  always_comb begin
    level_bits                = '0;
    level_bits[POS_TX_EMPTY]  = tx_hit;
    level_bits[POS_RX_AVAIL]  = rx_hit;
    level_bits[POS_GX_THRESH] = gx_bit;
  end

  // R6: FIFO disabled silences both inter-processor bits
  a_r6_ipc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ipc_fifo_en |-> (level_bits[POS_RX_AVAIL:POS_TX_EMPTY] == 2'b00));

  // R7: reserved and off modes never raise the geometry bit
  a_r7_gx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gx_irq_mode == 2'd0 || gx_irq_mode == 2'd3) |-> !level_bits[POS_GX_THRESH]);

  // R7: empty mode needs a zero count
  a_r7_gx_empty_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gx_irq_mode == 2'd2 && gx_fill != '0) |-> !level_bits[POS_GX_THRESH]);
endmodule

// File: rtl/irqf_latch.sv
module irqf_latch
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_vec,
  input  logic [WORD_W-1:0] clr_vec,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_next;

  assign q_next = (set_vec | (q & ~clr_vec)) & STORED_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R1/R3: every pulsed stored bit is set one edge later, clear or not
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & STORED_MASK)) |=>
      ((q & $past(set_vec & STORED_MASK)) == $past(set_vec & STORED_MASK)));

  // R2: a clear with no competing event empties the bit
  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec & STORED_MASK)) |=>
      ((q & $past(clr_vec & ~set_vec & STORED_MASK)) == '0));

  // R2: untouched flags hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && (set_vec & STORED_MASK) == '0) |=> $stable(q));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irqf_pkg::*;
#(
  parameter int unsigned GX_CNT_W  = 9,
  parameter int unsigned GX_THRESH = 127
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [WORD_W-1:0]   evt_pulse,
  input  logic                ipc_fifo_en,
  input  logic                ipc_send_irq_en,
  input  logic                ipc_send_empty,
  input  logic                ipc_recv_irq_en,
  input  logic                ipc_recv_empty,
  input  logic [1:0]          gx_irq_mode,
  input  logic [GX_CNT_W-1:0] gx_fill,
  input  logic                master_en,
  output logic                irq_out
);
  logic [WORD_W-1:0] acc_bits;
  logic [WORD_W-1:0] wr_flag_bits;
  logic [WORD_W-1:0] wr_en_bits;
  logic              sel_en;
  logic [WORD_W-1:0] level_bits;
  logic [WORD_W-1:0] stored_q;
  logic [WORD_W-1:0] clr_vec;
  logic [WORD_W-1:0] flag_word;
  logic [WORD_W-1:0] en_q;
  logic [WORD_W-1:0] pending;

  irqf_lane_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (bus_wr),
    .addr         (bus_addr),
    .size         (bus_size),
    .acc_bits     (acc_bits),
    .wr_flag_bits (wr_flag_bits),
    .wr_en_bits   (wr_en_bits),
    .sel_en       (sel_en)
  );

  irqf_level_gen #(
    .GX_CNT_W  (GX_CNT_W),
    .GX_THRESH (GX_THRESH)
  ) u_lvl (
    .clk             (clk),
    .rst_n           (rst_n),
    .ipc_fifo_en     (ipc_fifo_en),
    .ipc_send_irq_en (ipc_send_irq_en),
    .ipc_send_empty  (ipc_send_empty),
    .ipc_recv_irq_en (ipc_recv_irq_en),
    .ipc_recv_empty  (ipc_recv_empty),
    .gx_irq_mode     (gx_irq_mode),
    .gx_fill         (gx_fill),
    .level_bits      (level_bits)
  );

  assign clr_vec = wr_flag_bits & bus_wdata;

  irqf_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_pulse),
    .clr_vec (clr_vec),
    .q       (stored_q)
  );

  assign flag_word = stored_q | level_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q & ~wr_en_bits) | (bus_wdata & wr_en_bits);
  end

  assign bus_rdata = (sel_en ? en_q : flag_word) & acc_bits;
  assign pending   = flag_word & en_q;
  assign irq_out   = master_en && (|pending);

  // R5: unassigned positions never appear in the flag word
  a_r5_unassigned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_word & ~ASSIGNED_MASK) == '0);

  // R10: no request without the master enable
  a_r10_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq_out);

  // R10: no request without an enabled flag
  a_r10_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_word & en_q) == '0) |-> !irq_out);

  // R9: enable word holds when not written
  a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_bits == '0) |=> $stable(en_q));
endmodule

// File: tb/irq_flag_unit_bench.sv
module irq_flag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic        ipc_fifo_en = 1'b0;
  logic        ipc_send_irq_en = 1'b0;
  logic        ipc_send_empty = 1'b0;
  logic        ipc_recv_irq_en = 1'b0;
  logic        ipc_recv_empty = 1'b1;
  logic [1:0]  gx_irq_mode = 2'd0;
  logic [8:0]  gx_fill = '0;
  logic        master_en = 1'b0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];
  event  smp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_unit u_irq_flag_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .ipc_fifo_en(ipc_fifo_en),
    .ipc_send_irq_en(ipc_send_irq_en), .ipc_send_empty(ipc_send_empty),
    .ipc_recv_irq_en(ipc_recv_irq_en), .ipc_recv_empty(ipc_recv_empty),
    .gx_irq_mode(gx_irq_mode), .gx_fill(gx_fill), .master_en(master_en),
    .irq_out(irq_out)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(smp_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %08h expected %08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push_check(bit is_irq, logic [31:0] exp, string req);
    item_t it;
    it.is_irq = is_irq;
    it.exp    = exp;
    it.req    = req;
    #1;
    sb.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic rd(logic [2:0] a, logic [1:0] s, logic [31:0] exp, string req);
    bus_addr = a;
    bus_size = s;
    push_check(1'b0, exp, req);
  endtask

  task automatic irq_chk(logic exp, string req);
    push_check(1'b1, {31'd0, exp}, req);
  endtask

  task automatic wr(logic [2:0] a, logic [1:0] s, logic [31:0] d, logic [31:0] ev);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d; evt_pulse = ev;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt_pulse = '0;
  endtask

  task automatic pulse(logic [31:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9 / R10 reset state
    rd(3'd0, 2'd2, 32'h0, "R1 reset flags");
    rd(3'd4, 2'd2, 32'h0, "R9 reset enable");
    irq_chk(1'b0, "R10 reset irq");

    // R1 / R5 all pulses: only stored bits latch
    pulse(32'hFFFF_FFFF);
    rd(3'd0, 2'd2, 32'h01D9_3FFF, "R1 R5 latch all");

    // R2 / R4 byte clear on lane 1
    wr(3'd1, 2'd0, 32'h0000_FF00, '0);
    rd(3'd0, 2'd2, 32'h01D9_00FF, "R2 byte clear lane1");
    rd(3'd1, 2'd0, 32'h0000_0000, "R4 byte read lane1");
    rd(3'd0, 2'd0, 32'h0000_00FF, "R4 byte read lane0");
    wr(3'd3, 2'd0, 32'h0100_0000, '0);
    rd(3'd0, 2'd2, 32'h00D9_00FF, "R4 byte clear lane3");
    wr(3'd2, 2'd1, 32'h0001_0000, '0);
    rd(3'd2, 2'd1, 32'h00D8_0000, "R4 half read upper");
    // R4 misaligned halfword is inert
    wr(3'd1, 2'd1, 32'hFFFF_FFFF, '0);
    rd(3'd0, 2'd2, 32'h00D8_00FF, "R4 misaligned write");
    rd(3'd1, 2'd1, 32'h0000_0000, "R4 misaligned read");
    wr(3'd2, 2'd2, 32'hFFFF_FFFF, '0);
    rd(3'd0, 2'd2, 32'h00D8_00FF, "R4 misaligned word");
    // R4 byte write: other lanes untouched though data ones
    wr(3'd0, 2'd0, 32'hFFFF_FF00, '0);
    rd(3'd0, 2'd2, 32'h00D8_00FF, "R4 lane isolation");
    wr(3'd0, 2'd2, 32'h0000_0001, '0);
    rd(3'd0, 2'd2, 32'h00D8_00FE, "R2 word clear bit0");

    // R3 clear and event together
    wr(3'd0, 2'd2, 32'h0000_0002, 32'h0000_0002);
    rd(3'd0, 2'd2, 32'h00D8_00FE, "R3 set wins");
    wr(3'd0, 2'd2, 32'h0000_0002, '0);
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R2 clear after");

    // R5 pulses on unassigned bits
    pulse(32'hFE00_C000);
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R5 unassigned pulse");

    // R6 / R8 inter-processor level bits
    ipc_fifo_en = 1; ipc_send_irq_en = 1; ipc_send_empty = 1;
    ipc_recv_irq_en = 1; ipc_recv_empty = 0;
    rd(3'd0, 2'd2, 32'h00DE_00FC, "R6 both level bits");
    wr(3'd0, 2'd2, 32'h0006_0000, '0);
    rd(3'd0, 2'd2, 32'h00DE_00FC, "R8 level survives write");
    ipc_send_empty = 0;
    rd(3'd0, 2'd2, 32'h00DC_00FC, "R6 send not empty");
    ipc_recv_empty = 1;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R6 recv empty");
    ipc_send_empty = 1; ipc_recv_empty = 0; ipc_fifo_en = 0;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R6 fifo disabled");
    ipc_fifo_en = 1; ipc_send_irq_en = 0;
    rd(3'd0, 2'd2, 32'h00DC_00FC, "R6 send irq disabled");
    ipc_fifo_en = 0;

    // R7 geometry modes and threshold
    gx_irq_mode = 2'd1; gx_fill = 9'd127;
    rd(3'd0, 2'd2, 32'h00F8_00FC, "R7 mode1 at 127");
    gx_fill = 9'd128;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R7 mode1 at 128");
    gx_irq_mode = 2'd2; gx_fill = 9'd0;
    rd(3'd0, 2'd2, 32'h00F8_00FC, "R7 mode2 empty");
    gx_fill = 9'd1;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R7 mode2 one entry");
    gx_irq_mode = 2'd0; gx_fill = 9'd0;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R7 mode0");
    gx_irq_mode = 2'd3;
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R7 mode3");
    gx_irq_mode = 2'd0;

    // R9 / R10 enable word and request
    master_en = 1;
    irq_chk(1'b0, "R10 nothing enabled");
    wr(3'd4, 2'd2, 32'h0000_0004, '0);
    rd(3'd4, 2'd2, 32'h0000_0004, "R9 enable readback");
    rd(3'd6, 2'd0, 32'h0000_0000, "R9 enable byte lane2");
    irq_chk(1'b1, "R10 enabled flag");
    master_en = 0;
    irq_chk(1'b0, "R10 master off");
    master_en = 1;
    wr(3'd4, 2'd0, 32'h0000_0000, '0);
    irq_chk(1'b0, "R10 enable cleared");
    wr(3'd6, 2'd1, 32'h0020_0000, '0);
    rd(3'd4, 2'd2, 32'h0020_0000, "R9 half write enable");
    rd(3'd0, 2'd2, 32'h00D8_00FC, "R9 flags untouched");
    gx_irq_mode = 2'd1;
    irq_chk(1'b1, "R10 level bit request");
    gx_irq_mode = 2'd0;
    irq_chk(1'b0, "R10 level bit gone");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule